// File: doc/BRIEF.md
# Four-Lane Serial Audio Output Formatter

This block takes four stereo pairs of PCM samples and sends them out on four serial data lines that share one bit clock and one word clock. It runs from a master clock at 256 times the sample rate. The frame is divided into a left half and a right half of 32 bit periods each, and every bit period lasts four master clocks. A parallel load strobe captures all eight samples at once. The new values take effect at the next frame boundary, so a frame never mixes old and new samples.

A two-bit format select picks right-justified framing with sign extension, left-justified framing, or left-justified framing with a gated bit clock. Its fourth code parks the timing and silences every output. A width select says whether each sample carries 24, 20 or 16 valid bits. A mode select decides whether the block generates the word clock itself or follows an external one. In follower mode, every edge of the external word clock snaps the internal frame position to the start of the matching half, so a word-clock period of the wrong length never stalls the lanes. A mute input zeroes the data lines and leaves the clocks running.

Top module: `aud_serial_fmt`

## Requirements
- R1: A frame lasts 256 `clk` cycles and holds 64 bit periods of 4 cycles each. Periods 0 to 31 are the left half and periods 32 to 63 the right half. Each data line holds one slot bit for a whole bit period, with the MSB side first. All outputs are registered. While `rst` is high, `sdata`, `bclk` and `wclk_out` are 0. The first frame begins on the first clock edge after `rst` falls.
- R2: `fmt_sel`=00 gives right-justified framing. `bclk` is low for the first two cycles of each bit period and high for the last two, so it falls wherever the word clock changes. The last slot position (31) carries sample bit 0. Every position before the sample's top valid bit repeats that top bit (sign extension).
- R3: `fmt_sel`=01 gives left-justified framing. `bclk` is high for the first two cycles of each bit period and low for the last two, so it rises wherever the word clock changes. Slot position 0 carries the sample's top valid bit, and positions at or beyond the width are 0.
- R4: `fmt_sel`=11 gives the same data as R3. `bclk` pulses (high for the first two cycles) only in slot positions 0 to 23 of each half and stays low in positions 24 to 31.
- R5: `fmt_sel`=10 holds `bclk`, `wclk_out` and `sdata` at 0. On the first cycle after leaving this code, a new frame starts at left-half position 0.
- R6: `width_sel` encoding: 00 gives 24 valid bits, 01 gives 20, 10 gives 16, and 11 gives 24. The valid bits are the low bits of each 24-bit sample field. Bits above the width are ignored.
- R7: A cycle with `ld_valid` high captures `ld_samples`. Lane i takes its left sample from bits [48i+23:48i] and its right sample from bits [48i+47:48i+24]. Lane i drives `sdata[i]`. Captured samples are used from the next frame start onward.
- R8: `mode_sel`=00 (leader) drives `wclk_oe` high. `wclk_out` is high for the left half and low for the right half.
- R9: `mode_sel`=01 (follower) drives `wclk_oe` and `wclk_out` low. When `wclk_in` is first sampled high, left-half position 0 appears on the outputs starting two clock edges later.
- R10: In follower mode, when `wclk_in` is first sampled low, right-half position 0 appears two edges later, however long the preceding half was. With no edge, the count keeps running.
- R11: `mute` high forces all `sdata` lines to 0 from the next edge, while `bclk` and `wclk_out` keep their normal pattern.
- R12: `mode_sel`=10 or 11 gives leader timing on `wclk_out`, `wclk_oe` and `bclk`, with all `sdata` held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 per sample period |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Leader, follower or reserved mode |
| fmt_sel | input | 2 | Framing select or park code |
| width_sel | input | 2 | Valid sample width |
| mute | input | 1 | Zero all data lines |
| ld_valid | input | 1 | Sample load strobe |
| ld_samples | input | 192 | Eight packed 24-bit samples |
| wclk_in | input | 1 | External word clock in follower mode |
| wclk_out | output | 1 | Generated word clock |
| wclk_oe | output | 1 | High when the word clock is driven |
| bclk | output | 1 | Bit clock |
| sdata | output | 4 | Serial data, one line per stereo pair |

## Verification
The assertions assume the select inputs and `wclk_in` are synchronous to `clk`. They also assume `wclk_in` is a clean level, so that a single sampled change marks a real word-clock edge. The stimulus changes selects, loads and `wclk_in` only on falling clock edges, and only between captured frames. Follower-mode edges are placed at chosen offsets from the internal count, including a deliberately short half, to exercise the realignment jumps.

// File: rtl/aud_fmt_pkg.sv
package aud_fmt_pkg;

    localparam int LANES        = 4;
    localparam int SAMP_W       = 24;
    localparam int SLOT_BITS    = 32;
    localparam int MCLK_PER_BIT = 4;
    localparam int GATE_BITS    = SAMP_W;

    localparam int FRAME_MCLK = 2 * SLOT_BITS * MCLK_PER_BIT;
    localparam int CNT_W      = $clog2(FRAME_MCLK);
    localparam int PH_W       = $clog2(MCLK_PER_BIT);
    localparam int POS_W      = $clog2(SLOT_BITS);

    typedef enum logic [1:0] {
        FMT_RJ    = 2'b00,
        FMT_LJ    = 2'b01,
        FMT_HOLD  = 2'b10,
        FMT_GATED = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        MD_LEAD   = 2'b00,
        MD_FOLLOW = 2'b01,
        MD_RSV_A  = 2'b10,
        MD_RSV_B  = 2'b11
    } mode_e;

    // frame position: half, slot position, phase inside the bit period
    typedef struct packed {
        logic             half;
        logic [POS_W-1:0] pos;
        logic [PH_W-1:0]  ph;
    } tpos_t;

    function automatic int width_bits(input logic [1:0] sel);
        case (sel)
            2'b01:   return 20;
            2'b10:   return 16;
            default: return SAMP_W;
        endcase
    endfunction

    function automatic logic pick(input logic [SAMP_W-1:0] s, input int idx);
        logic b;
        b = 1'b0;
        for (int i = 0; i < SAMP_W; i++) begin
            if (i == idx) b = s[i];
        end
        return b;
    endfunction

    function automatic logic slot_bit(input logic [SAMP_W-1:0] s,
                                      input logic [1:0]        wsel,
                                      input fmt_e              f,
                                      input logic [POS_W-1:0]  pos);
        int   w;
        int   p;
        logic b;
        w = width_bits(wsel);
        p = int'(pos);
        if (f == FMT_RJ) begin
            if (p < SLOT_BITS - w) b = pick(s, w - 1);
            else                   b = pick(s, SLOT_BITS - 1 - p);
        end else begin
            if (p < w) b = pick(s, w - 1 - p);
            else       b = 1'b0;
        end
        return b;
    endfunction

endpackage

// File: rtl/aud_fmt_timebase.sv
module aud_fmt_timebase
    import aud_fmt_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          follow,
    input  logic          wclk_in,
    output logic [CW-1:0] cnt_nxt,
    output logic          frame_start
);
    localparam logic [CW-1:0] HALF_START = CW'(1) << (CW - 1);

    logic [CW-1:0] cnt;
    logic          wsync;
    logic          wprev;
    logic          rise;
    logic          fall;

    always_comb begin
        rise = wsync & ~wprev;
        fall = ~wsync & wprev;
        if (hold)                cnt_nxt = '1;
        else if (follow && rise) cnt_nxt = '0;
        else if (follow && fall) cnt_nxt = HALF_START;
        else                     cnt_nxt = cnt + CW'(1);
        frame_start = (cnt_nxt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '1;
            wsync <= 1'b0;
            wprev <= 1'b0;
        end else begin
            cnt   <= cnt_nxt;
            wsync <= wclk_in;
            wprev <= wsync;
        end
    end

    a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
        (!hold && !(follow && (rise || fall))) |=> cnt == CW'($past(cnt) + CW'(1)));
    a_r5_hold_parks: assert property (@(posedge clk) disable iff (rst)
        hold |=> cnt == '1);
    a_r9_rise_align: assert property (@(posedge clk) disable iff (rst)
        (!hold && follow && rise) |=> cnt == '0);
    a_r10_fall_align: assert property (@(posedge clk) disable iff (rst)
        (!hold && follow && fall) |=> cnt == HALF_START);

endmodule

// File: rtl/aud_fmt_clkgen.sv
module aud_fmt_clkgen
    import aud_fmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  tpos_t t,
    input  fmt_e  fmt,
    input  mode_e mode,
    output logic  bclk,
    output logic  wclk_out,
    output logic  wclk_oe
);
    logic follow;
    logic hold;
    logic b_n;
    logic w_n;

    always_comb begin
        follow = (mode == MD_FOLLOW);
        hold   = (fmt == FMT_HOLD);
        case (fmt)
            FMT_RJ:    b_n = t.ph[PH_W-1];
            FMT_LJ:    b_n = ~t.ph[PH_W-1];
            FMT_GATED: b_n = (int'(t.pos) < GATE_BITS) && !t.ph[PH_W-1];
            default:   b_n = 1'b0;
        endcase
        w_n = (!follow && !hold) ? ~t.half : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk     <= 1'b0;
            wclk_out <= 1'b0;
            wclk_oe  <= 1'b0;
        end else begin
            bclk     <= b_n;
            wclk_out <= w_n;
            wclk_oe  <= !follow;
        end
    end

    a_r5_clocks_quiet: assert property (@(posedge clk) disable iff (rst)
        hold |=> (!bclk && !wclk_out));
    a_r9_follow_release: assert property (@(posedge clk) disable iff (rst)
        follow |=> (!wclk_oe && !wclk_out));

endmodule

// File: rtl/aud_fmt_lane.sv
module aud_fmt_lane
    import aud_fmt_pkg::*;
#(
    parameter int SW = SAMP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [SW-1:0] ld_left,
    input  logic [SW-1:0] ld_right,
    input  logic          frame_start,
    input  tpos_t         t,
    input  logic [1:0]    wsel,
    input  fmt_e          fmt,
    input  logic          kill,
    output logic          sd
);
    logic [SW-1:0] pend_l, pend_r;
    logic [SW-1:0] act_l, act_r;
    logic [SW-1:0] act_l_n, act_r_n;
    logic [SW-1:0] word;

    always_comb begin
        act_l_n = frame_start ? pend_l : act_l;
        act_r_n = frame_start ? pend_r : act_r;
        word    = t.half ? act_r_n : act_l_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_l <= '0;
            pend_r <= '0;
            act_l  <= '0;
            act_r  <= '0;
            sd     <= 1'b0;
        end else begin
            if (ld) begin
                pend_l <= ld_left;
                pend_r <= ld_right;
            end
            act_l <= act_l_n;
            act_r <= act_r_n;
            sd    <= kill ? 1'b0 : slot_bit(word, wsel, fmt, t.pos);
        end
    end

    a_r11_kill_low: assert property (@(posedge clk) disable iff (rst)
        kill |=> !sd);

endmodule

// File: rtl/aud_serial_fmt.sv
module aud_serial_fmt
    import aud_fmt_pkg::*;
#(
    parameter int NL = LANES,
    parameter int SW = SAMP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    input  logic [1:0]       fmt_sel,
    input  logic [1:0]       width_sel,
    input  logic             mute,
    input  logic             ld_valid,
    input  logic [NL*2*SW-1:0] ld_samples,
    input  logic             wclk_in,
    output logic             wclk_out,
    output logic             wclk_oe,
    output logic             bclk,
    output logic [NL-1:0]    sdata
);
    localparam int PAIR_W = 2 * SW;

    fmt_e         fmt;
    mode_e        mode;
    logic         hold;
    logic         follow;
    logic         kill;
    logic [CNT_W-1:0] cnt_nxt;
    logic         frame_start;
    tpos_t        t;

    always_comb begin
        fmt    = fmt_e'(fmt_sel);
        mode   = mode_e'(mode_sel);
        hold   = (fmt == FMT_HOLD);
        follow = (mode == MD_FOLLOW);
        kill   = mute | hold | mode_sel[1];
        t      = tpos_t'(cnt_nxt);
    end

    aud_fmt_timebase #(.CW(CNT_W)) u_tb (
        .clk         (clk),
        .rst         (rst),
        .hold        (hold),
        .follow      (follow),
        .wclk_in     (wclk_in),
        .cnt_nxt     (cnt_nxt),
        .frame_start (frame_start)
    );

    aud_fmt_clkgen u_ck (
        .clk      (clk),
        .rst      (rst),
        .t        (t),
        .fmt      (fmt),
        .mode     (mode),
        .bclk     (bclk),
        .wclk_out (wclk_out),
        .wclk_oe  (wclk_oe)
    );

    for (genvar i = 0; i < NL; i++) begin : g_lane
        aud_fmt_lane #(.SW(SW)) u_lane (
            .clk         (clk),
            .rst         (rst),
            .ld          (ld_valid),
            .ld_left     (ld_samples[i*PAIR_W +: SW]),
            .ld_right    (ld_samples[i*PAIR_W + SW +: SW]),
            .frame_start (frame_start),
            .t           (t),
            .wsel        (width_sel),
            .fmt         (fmt),
            .kill        (kill),
            .sd          (sdata[i])
        );
    end

    a_r12_reserved_silent: assert property (@(posedge clk) disable iff (rst)
        mode_sel[1] |=> sdata == '0);
    a_r11_mute_silent: assert property (@(posedge clk) disable iff (rst)
        mute |=> sdata == '0);

endmodule

// File: tb/aud_serial_fmt_bench.sv
module aud_serial_fmt_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   mode_sel = 2'b00;
    logic [1:0]   fmt_sel = 2'b01;
    logic [1:0]   width_sel = 2'b00;
    logic         mute = 1'b0;
    logic         ld_valid = 1'b0;
    logic [191:0] ld_samples = '0;
    logic         wclk_in = 1'b0;
    logic         wclk_out;
    logic         wclk_oe;
    logic         bclk;
    logic [3:0]   sdata;

    int n_chk = 0;
    int n_fail = 0;
    logic [23:0] smp [8];

    always #10 clk = ~clk;

    aud_serial_fmt u_aud_serial_fmt (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .fmt_sel(fmt_sel),
        .width_sel(width_sel), .mute(mute), .ld_valid(ld_valid),
        .ld_samples(ld_samples), .wclk_in(wclk_in), .wclk_out(wclk_out),
        .wclk_oe(wclk_oe), .bclk(bclk), .sdata(sdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int wbits(input logic [1:0] s);
        return (s == 2'b01) ? 20 : (s == 2'b10) ? 16 : 24;
    endfunction

    // slot vector built MSB-first, then indexed by position
    function automatic logic exp_bit(input logic [23:0] s, input int w,
                                     input logic [1:0] f, input int p);
        logic [31:0] mask;
        logic [31:0] v;
        logic [31:0] slot;
        mask = (32'd1 << w) - 32'd1;
        v = {8'd0, s} & mask;
        if (f == 2'b00) begin
            if (((v >> (w - 1)) & 32'd1) != 0) v = v | ~mask;
            slot = v;
        end else begin
            slot = v << (32 - w);
        end
        return slot[31 - p];
    endfunction

    task automatic load(input int seed);
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            smp[i] = 24'((seed * 32'h9E3779B1 + i * 32'h7F4A7C15) >> 5);
            if (i % 2 == 0) smp[i][23] = 1'b1;
            if (i == 1 || i == 4) begin
                smp[i][19] = 1'b1;
                smp[i][15] = 1'b0;
            end
            if (i == 2) begin
                smp[i][19] = 1'b0;
                smp[i][15] = 1'b1;
            end
            ld_samples[(i/2)*48 + (i%2)*24 +: 24] = smp[i];
        end
        ld_valid = 1'b1;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    // sync=1: wait for a word-clock rise; otherwise caller is at position k0
    task automatic grab(input string req, input bit sync, input bit chkw,
                        input logic [1:0] f, input int w, input bit zero,
                        input int k0);
        logic prev;
        int   guard;
        logic eb;
        logic ed;
        if (sync) begin
            prev  = wclk_out;
            guard = 0;
            @(negedge clk);
            while (!(wclk_out && !prev) && guard < 1000) begin
                prev = wclk_out;
                @(negedge clk);
                guard++;
            end
        end
        for (int k = k0; k < 64; k++) begin
            for (int ph = 0; ph < 4; ph++) begin
                if (!(k == k0 && ph == 0)) @(negedge clk);
                case (f)
                    2'b00:   eb = (ph >= 2);
                    2'b01:   eb = (ph < 2);
                    2'b11:   eb = ((k % 32) < 24) && (ph < 2);
                    default: eb = 1'b0;
                endcase
                chk(bclk == eb, req, "bclk", int'(bclk), int'(eb));
                if (ph == 1) begin
                    if (chkw) chk(wclk_out == (k < 32), req, "wclk_out",
                                  int'(wclk_out), int'(k < 32));
                    for (int l = 0; l < 4; l++) begin
                        ed = zero ? 1'b0 : exp_bit(smp[2*l + (k >= 32 ? 1 : 0)], w, f, k % 32);
                        chk(sdata[l] == ed, req, $sformatf("lane%0d bit%0d", l, k),
                            int'(sdata[l]), int'(ed));
                    end
                end
            end
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(sdata == 4'd0, "R1", "reset sdata", int'(sdata), 0);
        chk(bclk == 1'b0, "R1", "reset bclk", int'(bclk), 0);
        chk(wclk_out == 1'b0, "R1", "reset wclk", int'(wclk_out), 0);
    endtask

    task automatic t_lj24;
        mode_sel = 2'b00; fmt_sel = 2'b01; width_sel = 2'b00;
        load(3);
        chk(wclk_oe == 1'b1, "R8", "wclk_oe leader", int'(wclk_oe), 1);
        grab("R3", 1'b1, 1'b1, 2'b01, 24, 1'b0, 0);
    endtask

    task automatic t_rj20;
        @(negedge clk); fmt_sel = 2'b00; width_sel = 2'b01;
        load(7);
        grab("R2", 1'b1, 1'b1, 2'b00, 20, 1'b0, 0);
    endtask

    task automatic t_lj16;
        @(negedge clk); fmt_sel = 2'b01; width_sel = 2'b10;
        load(11);
        grab("R6", 1'b1, 1'b1, 2'b01, 16, 1'b0, 0);
    endtask

    task automatic t_rj16;
        @(negedge clk); fmt_sel = 2'b00; width_sel = 2'b10;
        load(19);
        grab("R6", 1'b1, 1'b1, 2'b00, 16, 1'b0, 0);
    endtask

    task automatic t_gated;
        @(negedge clk); fmt_sel = 2'b11; width_sel = 2'b00;
        load(23);
        grab("R4", 1'b1, 1'b1, 2'b11, 24, 1'b0, 0);
    endtask

    task automatic t_late_load;
        // R7: samples loaded mid-frame must not show before the next frame start
        @(negedge clk); fmt_sel = 2'b01; width_sel = 2'b00;
        load(29);
        grab("R7", 1'b1, 1'b1, 2'b01, 24, 1'b0, 0);
    endtask

    task automatic t_mute;
        @(negedge clk); mute = 1'b1; fmt_sel = 2'b01;
        grab("R11", 1'b1, 1'b1, 2'b01, 24, 1'b1, 0);
        @(negedge clk); mute = 1'b0;
    endtask

    task automatic t_hold;
        @(negedge clk); fmt_sel = 2'b10;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            chk(bclk == 1'b0 && wclk_out == 1'b0 && sdata == 4'd0, "R5",
                "parked outputs", int'({bclk, wclk_out, sdata}), 0);
        end
        fmt_sel = 2'b01;
        @(negedge clk);
        chk(wclk_out == 1'b1, "R5", "restart wclk", int'(wclk_out), 1);
        grab("R5", 1'b0, 1'b1, 2'b01, 24, 1'b0, 0);
    endtask

    task automatic t_reserved;
        @(negedge clk); mode_sel = 2'b10;
        grab("R12", 1'b1, 1'b1, 2'b01, 24, 1'b1, 0);
        chk(wclk_oe == 1'b1, "R12", "wclk_oe reserved", int'(wclk_oe), 1);
        @(negedge clk); mode_sel = 2'b11;
        grab("R12", 1'b1, 1'b1, 2'b01, 24, 1'b1, 0);
    endtask

    task automatic t_follow;
        @(negedge clk); mode_sel = 2'b01; fmt_sel = 2'b01; width_sel = 2'b00;
        load(31);
        repeat (57) @(negedge clk);
        chk(wclk_oe == 1'b0 && wclk_out == 1'b0, "R9", "follower release",
            int'({wclk_oe, wclk_out}), 0);
        wclk_in = 1'b1;
        repeat (2) @(negedge clk);
        grab("R9", 1'b0, 1'b0, 2'b01, 24, 1'b0, 0);
    endtask

    task automatic t_follow_short;
        @(negedge clk); fmt_sel = 2'b00; width_sel = 2'b01;
        wclk_in = 1'b0;
        repeat (100) @(negedge clk);
        wclk_in = 1'b1;
        repeat (2) @(negedge clk);
        repeat (58) @(negedge clk);
        wclk_in = 1'b0;
        repeat (2) @(negedge clk);
        grab("R10", 1'b0, 1'b0, 2'b00, 20, 1'b0, 32);
        // no further edge: count rolls into a full frame on its own
        @(negedge clk);
        grab("R10", 1'b0, 1'b0, 2'b00, 20, 1'b0, 0);
    endtask

    initial begin : main
        repeat (4) @(negedge clk);
        t_reset;
        rst = 1'b0;
        t_lj24;
        t_rj20;
        t_lj16;
        t_rj16;
        t_gated;
        t_late_load;
        t_mute;
        t_hold;
        t_reserved;
        t_follow;
        t_follow_short;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule